// File: doc/BRIEF.md
# Programmable Tap-Select Binary Timer

This block is a 24-stage binary divider used as an interval timer. An external timing input is brought into the system clock domain, and each of its falling edges advances the chain. A 4-bit select code chooses which stage drives the single timer output, so the output divides the timing input by a power of two chosen at run time. A skip flag takes the first eight stages out of the clock path. The chain then behaves as a 16-stage divider in which the same code reaches ratios 2 to 65536.

An output latch gives the timer two start modes. A set request drives the output high and clears the chain. The first qualified falling edge after release drops the output, and counting starts on the edge after that. A clear request drives the output low and clears the chain. Two hold inputs freeze the chain while the timing source keeps running: one is a count hold and the other is a source gate. An optional one-shot turns each rising edge of the selected stage into a pulse of programmable length in system-clock cycles, and a new edge restarts the pulse.

A test configuration splits the chain into three 8-stage sections that count side by side. Every stage can then reach one after 255 edges. The chain is joined again afterwards and rolled over with a single edge.

Top module: `tap_timer`

## Requirements
- R1: The timing input passes through a two-flop synchronizer. The chain advances by exactly one for each falling edge of the timing input and never on a rising edge.
- R2: With the skip flag low, select code k (0..15) routes stage 9+k to the output. With the skip flag high, stages 1..8 receive no edges, and code k routes the stage that divides by 2^(k+1).
- R3: While set is high and clear is low, the output is high and every stage is zero. After set falls, the first qualified falling edge drives the output low without counting, and the second edge counts.
- R4: While clear is high, the output is low and every stage is zero. Clear wins over set unless the test configuration is active.
- R5: While the count hold is high, falling edges change neither the chain nor the output. The first falling edge after the hold falls advances the chain.
- R6: With the one-shot disabled, the output equals the selected stage. It is a 50% duty square wave dividing the edge rate by 2^n, where n is the number of the selected stage.
- R7: Counting from a cleared chain, the output first rises on falling edge number 2^(n-1).
- R8: With the one-shot enabled, each rising edge of the selected stage makes the output high for exactly pulse_len_i system-clock cycles, starting one cycle later. A rising edge during a pulse restarts the full length.
- R9: With skip, set and clear all high, the chain splits into three 8-stage sections that each advance on every qualified edge, and no clear applies. After 255 edges every stage is one.
- R10: When set, clear and skip are released together, the chain is serial again. One falling edge then takes every stage from one to zero.
- R11: The source gate input, when high, has exactly the effect of the count hold.
- R12: After system reset every stage and the output latch are zero and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Asynchronous timing input; falling edges advance the chain |
| set_i | input | 1 | Set request: output high, chain cleared |
| clr_i | input | 1 | Clear request: output low, chain cleared |
| hold_i | input | 1 | Count hold |
| gate_off_i | input | 1 | Timing source gate; acts like the count hold |
| skip8_i | input | 1 | Takes stages 1..8 out of the clock path |
| sel_i | input | 4 | Stage select code |
| pulse_en_i | input | 1 | Enables the one-shot output shaping |
| pulse_len_i | input | 16 | One-shot length in system-clock cycles |
| tap_o | output | 1 | Timer output |

## Verification
The divider is driven with short select codes under the skip flag, where the full output waveform is compared edge by edge against bit k of the edge count. It is also driven with the shortest code without the skip flag, which shows that 255 edges leave the output low and edge 256 raises it. Switching the skip flag after an odd edge count shows whether the lower eight stages were clocked. The set sequence tells a design that counts on the first edge after release from one that waits for the second. One-shot runs with a short length and a long length tell separate pulses apart from a pulse that restarts. The split test fills all sections and sweeps every select code, and the final rollover proves that the lower section, which the output cannot show directly, was full.

// File: rtl/tt_pkg.sv
package tt_pkg;

    localparam int SECT_W_DEF   = 8;
    localparam int NUM_SECT_DEF = 3;
    localparam int SEL_W_DEF    = 4;
    localparam int LEN_W_DEF    = 16;

    typedef enum logic [1:0] {
        CH_SERIES = 2'd0,
        CH_SKIP   = 2'd1,
        CH_SPLIT  = 2'd2
    } chain_mode_t;

    function automatic chain_mode_t pick_mode(input logic skip8,
                                              input logic set_req,
                                              input logic clr_req);
        if (skip8 && set_req && clr_req) return CH_SPLIT;
        else if (skip8)                  return CH_SKIP;
        else                             return CH_SERIES;
    endfunction

endpackage

// File: rtl/tt_edge_sync.sv
module tt_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic fall_o
);
    logic meta_q, sync_q, last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign fall_o = last_q && !sync_q;
endmodule

// File: rtl/tt_chain.sv
module tt_chain
    import tt_pkg::*;
#(
    parameter int SECT_W   = SECT_W_DEF,
    parameter int NUM_SECT = NUM_SECT_DEF,
    localparam int STAGES  = SECT_W * NUM_SECT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              adv,
    input  chain_mode_t       mode,
    output logic [STAGES-1:0] stage_q
);
    logic [NUM_SECT-1:0] cin;

    // Carry into each section depends on the chain configuration.
    always_comb begin
        logic ripple;
        ripple = adv && (mode == CH_SERIES);
        for (int i = 0; i < NUM_SECT; i++) begin
            if (mode == CH_SPLIT)
                cin[i] = adv;
            else if (mode == CH_SKIP && i == 1)
                cin[i] = adv;
            else
                cin[i] = ripple;
            ripple = cin[i] && (&stage_q[i*SECT_W +: SECT_W]);
        end
    end

    for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
        logic [SECT_W-1:0] sec_q;
        always_ff @(posedge clk) begin
            if (rst || clear)
                sec_q <= '0;
            else if (cin[g])
                sec_q <= sec_q + 1'b1;
        end
        assign stage_q[g*SECT_W +: SECT_W] = sec_q;
    end
endmodule

// File: rtl/tt_oneshot.sv
module tt_oneshot #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             en,
    input  logic             level_in,
    input  logic [LEN_W-1:0] len,
    output logic             pulse_o
);
    logic             prev_q;
    logic [LEN_W-1:0] left_q;
    logic             rise;

    assign rise = level_in && !prev_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            prev_q <= 1'b0;
            left_q <= '0;
        end else begin
            prev_q <= level_in;
            if (en && rise)
                left_q <= len;
            else if (left_q != '0)
                left_q <= left_q - 1'b1;
        end
    end

    assign pulse_o = en && (left_q != '0);
endmodule

// File: rtl/tap_timer.sv
module tap_timer
    import tt_pkg::*;
#(
    parameter int SECT_W   = SECT_W_DEF,
    parameter int NUM_SECT = NUM_SECT_DEF,
    parameter int SEL_W    = SEL_W_DEF,
    parameter int LEN_W    = LEN_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_in,
    input  logic             set_i,
    input  logic             clr_i,
    input  logic             hold_i,
    input  logic             gate_off_i,
    input  logic             skip8_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             pulse_en_i,
    input  logic [LEN_W-1:0] pulse_len_i,
    output logic             tap_o
);
    localparam int STAGES = SECT_W * NUM_SECT;
    localparam int IDX_W  = $clog2(STAGES);

    chain_mode_t       mode;
    logic              fall, adv_raw, chain_adv, chain_clr;
    logic              latch_q;
    logic [STAGES-1:0] stage_q;
    logic [IDX_W-1:0]  tap_idx;
    logic              tap_raw, shaped;

    assign mode      = pick_mode(skip8_i, set_i, clr_i);
    assign chain_clr = (set_i || clr_i) && (mode != CH_SPLIT);
    assign adv_raw   = fall && !hold_i && !gate_off_i;
    assign chain_adv = adv_raw && !latch_q &&
                       ((mode == CH_SPLIT) || (!set_i && !clr_i));

    tt_edge_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (tick_in),
        .fall_o   (fall)
    );

    // Output latch: set drives it high, the first qualified edge after release drops it.
    always_ff @(posedge clk) begin
        if (rst)
            latch_q <= 1'b0;
        else if (mode == CH_SPLIT || clr_i)
            latch_q <= 1'b0;
        else if (set_i)
            latch_q <= 1'b1;
        else if (adv_raw)
            latch_q <= 1'b0;
    end

    tt_chain #(
        .SECT_W   (SECT_W),
        .NUM_SECT (NUM_SECT)
    ) u_chain (
        .clk     (clk),
        .rst     (rst),
        .clear   (chain_clr),
        .adv     (chain_adv),
        .mode    (mode),
        .stage_q (stage_q)
    );

    // The select code always addresses the stages above the skippable section.
    assign tap_idx = IDX_W'(sel_i) + IDX_W'(SECT_W);
    assign tap_raw = stage_q[tap_idx];

    logic os_pulse;
    tt_oneshot #(
        .LEN_W (LEN_W)
    ) u_oneshot (
        .clk      (clk),
        .rst      (rst),
        .clear    (chain_clr),
        .en       (pulse_en_i),
        .level_in (tap_raw),
        .len      (pulse_len_i),
        .pulse_o  (os_pulse)
    );

    assign shaped = pulse_en_i ? os_pulse : tap_raw;
    assign tap_o  = latch_q || shaped;
endmodule

// File: rtl/tt_checker.sv
module tt_checker #(
    parameter int SEL_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             set_i,
    input logic             clr_i,
    input logic             hold_i,
    input logic             gate_off_i,
    input logic             skip8_i,
    input logic [SEL_W-1:0] sel_i,
    input logic             pulse_en_i,
    input logic             tap_o
);
    a_r3_set_drives_high: assert property (@(posedge clk) disable iff (rst)
        (set_i && !clr_i) |=> tap_o);

    a_r4_clear_drives_low: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !tap_o);

    a_r5_hold_freezes: assert property (@(posedge clk) disable iff (rst)
        (hold_i && !set_i && !clr_i && !pulse_en_i) |=>
        ($stable(tap_o) || !$stable(sel_i) || !$stable(skip8_i) || !$stable(pulse_en_i)));

    a_r11_gate_freezes: assert property (@(posedge clk) disable iff (rst)
        (gate_off_i && !set_i && !clr_i && !pulse_en_i) |=>
        ($stable(tap_o) || !$stable(sel_i) || !$stable(skip8_i) || !$stable(pulse_en_i)));

    a_r12_low_after_reset: assert property (@(posedge clk)
        (rst && !set_i) |=> !tap_o);
endmodule

bind tap_timer tt_checker #(.SEL_W(SEL_W)) u_tt_checker (
    .clk        (clk),
    .rst        (rst),
    .set_i      (set_i),
    .clr_i      (clr_i),
    .hold_i     (hold_i),
    .gate_off_i (gate_off_i),
    .skip8_i    (skip8_i),
    .sel_i      (sel_i),
    .pulse_en_i (pulse_en_i),
    .tap_o      (tap_o)
);

// File: tb/tap_timer_bench.sv
module tap_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_in = 1'b0;
    logic        set_i = 1'b0, clr_i = 1'b0, hold_i = 1'b0, gate_off_i = 1'b0;
    logic        skip8_i = 1'b0, pulse_en_i = 1'b0;
    logic [3:0]  sel_i = 4'd0;
    logic [15:0] pulse_len_i = 16'd0;
    logic        tap_o;

    int checks = 0, fails = 0;
    int run_len = 0, last_w = 0, pulses = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tap_timer u_tap_timer (
        .clk(clk), .rst(rst), .tick_in(tick_in), .set_i(set_i), .clr_i(clr_i),
        .hold_i(hold_i), .gate_off_i(gate_off_i), .skip8_i(skip8_i), .sel_i(sel_i),
        .pulse_en_i(pulse_en_i), .pulse_len_i(pulse_len_i), .tap_o(tap_o)
    );

    // Pulse-width monitor on the output.
    always @(negedge clk) begin
        if (tap_o) run_len++;
        else begin
            if (run_len != 0) begin
                last_w = run_len;
                pulses++;
            end
            run_len = 0;
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic one_edge();
        tick_in = 1'b1;
        repeat (3) @(negedge clk);
        tick_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) one_edge();
    endtask

    task automatic clear_chain();
        clr_i = 1'b1;
        repeat (2) @(negedge clk);
        clr_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(tap_o, 0, "R12 output low after reset");
    endtask

    task automatic t_divide();
        // R6/R7 short ratio under skip: code 2 -> divide by 8
        skip8_i = 1'b1; sel_i = 4'd2;
        clear_chain();
        for (int k = 1; k <= 16; k++) begin
            one_edge();
            chk(tap_o, (k >> 2) & 1, $sformatf("R6 skip code2 edge %0d", k));
        end
        // R2: top code under skip stays low after 16 edges
        sel_i = 4'd15;
        @(negedge clk);
        chk(tap_o, 0, "R2 skip code15 low");
        // R7 without skip: code 0 is stage 9, first rise on edge 256
        skip8_i = 1'b0; sel_i = 4'd0;
        clear_chain();
        edges(255);
        chk(tap_o, 0, "R7 stage9 low after 255 edges");
        one_edge();
        chk(tap_o, 1, "R7 stage9 high on edge 256");
    endtask

    task automatic t_skip_unclocked();
        skip8_i = 1'b1; sel_i = 4'd0;
        clear_chain();
        edges(3);
        skip8_i = 1'b0;
        @(negedge clk);
        chk(tap_o, 1, "R2 lower stages not clocked under skip");
    endtask

    task automatic t_set();
        skip8_i = 1'b1; sel_i = 4'd0;
        set_i = 1'b1;
        repeat (2) @(negedge clk);
        chk(tap_o, 1, "R3 output high during set");
        set_i = 1'b0;
        @(negedge clk);
        chk(tap_o, 1, "R3 output stays high after release");
        one_edge();
        chk(tap_o, 0, "R3 first edge drops output");
        one_edge();
        chk(tap_o, 1, "R3 second edge counts");
    endtask

    task automatic t_clear();
        clr_i = 1'b1;
        @(negedge clk);
        chk(tap_o, 0, "R4 clear drives low");
        set_i = 1'b1; skip8_i = 1'b0;
        repeat (2) @(negedge clk);
        chk(tap_o, 0, "R4 clear wins over set");
        set_i = 1'b0; clr_i = 1'b0;
        @(negedge clk);
        chk(tap_o, 0, "R4 chain cleared");
    endtask

    task automatic t_hold(input bit use_gate);
        string tg;
        tg = use_gate ? "R11" : "R5";
        skip8_i = 1'b1; sel_i = 4'd0;
        clear_chain();
        one_edge();
        chk(tap_o, 1, {tg, " one edge before hold"});
        if (use_gate) gate_off_i = 1'b1; else hold_i = 1'b1;
        edges(3);
        chk(tap_o, 1, {tg, " edges ignored while held"});
        gate_off_i = 1'b0; hold_i = 1'b0;
        one_edge();
        chk(tap_o, 0, {tg, " first edge after release counts"});
    endtask

    task automatic t_oneshot();
        skip8_i = 1'b1; sel_i = 4'd0;
        pulse_en_i = 1'b1; pulse_len_i = 16'd5;
        clear_chain();
        pulses = 0;
        edges(4);
        repeat (10) @(negedge clk);
        chk(pulses, 2, "R8 one pulse per stage rise");
        chk(last_w, 5, "R8 pulse width");
        pulse_len_i = 16'd40;
        clear_chain();
        pulses = 0;
        edges(4);
        repeat (60) @(negedge clk);
        chk(pulses, 1, "R8 retrigger merges pulses");
        chk(last_w, 54, "R8 retrigger width");
        pulse_en_i = 1'b0;
    endtask

    task automatic t_split();
        skip8_i = 1'b0;
        clear_chain();
        skip8_i = 1'b1; set_i = 1'b1; clr_i = 1'b1;
        @(negedge clk);
        edges(255);
        sel_i = 4'd7;
        @(negedge clk);
        chk(tap_o, 1, "R9 split section full");
        set_i = 1'b0; clr_i = 1'b0; skip8_i = 1'b0;
        @(negedge clk);
        for (int s = 0; s < 16; s++) begin
            sel_i = 4'(s);
            @(negedge clk);
            chk(tap_o, 1, $sformatf("R9 stage %0d is one", s + 9));
        end
        one_edge();
        for (int s = 0; s < 16; s++) begin
            sel_i = 4'(s);
            @(negedge clk);
            chk(tap_o, 0, $sformatf("R10 stage %0d rolled to zero", s + 9));
        end
        // R1: rising edge alone does not advance
        sel_i = 4'd0; skip8_i = 1'b1;
        tick_in = 1'b1;
        repeat (6) @(negedge clk);
        chk(tap_o, 0, "R1 rising edge ignored");
        tick_in = 1'b0;
        repeat (4) @(negedge clk);
        chk(tap_o, 1, "R1 falling edge advances");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_divide();
        t_skip_unclocked();
        t_set();
        t_clear();
        t_hold(1'b0);
        t_hold(1'b1);
        t_oneshot();
        t_split();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule